// File: doc/BRIEF.md
# Auxiliary ADC Conversion Sequencer

This block runs a successive-approximation auxiliary converter from the system clock. A start strobe launches a measurement. The block captures two 3-bit settings at that moment: a clock-divisor code and an averaging code. It then makes one or more conversions and places the averaged 10-bit value in a result register. The comparator and the trial DAC are analog parts outside the block. Here they appear only as a 10-bit trial-code output and a single comparator input bit.

The block divides the system clock into an enable tick. Each conversion takes exactly twelve ticks: one for sampling, ten for bit decisions from MSB to LSB, and one for loading. The block adds the codes from all conversions in the measurement and scales the sum down by the number of conversions. Busy stays high for the whole measurement. A one-cycle done pulse marks the cycle in which the result register is written.

Top module: `aux_conv_seq`

## Requirements
- R1: After reset, busy_o, done_o, result_o and dac_code_o are all 0.
- R2: The divisor code k (0 to 7) gives a tick every 2^k system clocks. A measurement keeps busy_o high for exactly 12 × (conversion count) × 2^k cycles, counted from the cycle after start_i is accepted.
- R3: Averaging codes 0 to 5 select 1, 2, 4, 8, 16 and 32 conversions. Codes 6 and 7 both select 32.
- R4: Each conversion is a frame of 12 ticks. The frame has a sample tick, ten decision ticks and a load tick. dac_code_o is 0 before the sample tick. After the sample tick it is 512, with only bit 9 set.
- R5: Bits are decided from bit 9 down to bit 0. When cmp_i is 1 at a decision tick, the trial bit is kept; otherwise it is cleared. At the same tick, the next lower bit is set. A comparator that reports (trial code ≤ input level) therefore gives the input level as the code.
- R6: result_o equals the sum of the conversion codes shifted right by log2 of the conversion count, which is floor division.
- R7: start_i is ignored while busy_o is high. Changes to div_sel_i and avg_sel_i during a measurement have no effect on it.
- R8: done_o is high for exactly one cycle. That cycle is the first cycle with busy_o low after a measurement.
- R9: result_o changes only in a cycle where done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| div_sel_i | input | 3 | Conversion-clock divisor code |
| avg_sel_i | input | 3 | Averaging code |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| dac_code_o | output | 10 | Trial code to the DAC |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle pulse when the result is written |
| result_o | output | 10 | Averaged conversion result |

## Verification
The assertions check several things on every cycle. The divider count stays within the latched limit. The frame step never passes the load step, and the trial code is zero in the sample phase. The accumulator never exceeds 1023 times the number of conversions already summed. The latched settings stay fixed while busy. Busy falls only together with a single-cycle done, and the result moves only on done. Only the bench's scenarios can show that the measurement length matches 12 × count × divisor for each code. They also show that the SAR search finds the comparator's level, that averaging of varying inputs rounds down correctly, and that start strobes and setting changes made mid-measurement are really ignored.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

    // Phase of a conversion frame, decoded from the step counter
    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_DECIDE = 2'd1,
        PH_LOAD   = 2'd2
    } frame_phase_e;

    // Step 0 samples, steps 1..res_w decide bits, step res_w+1 loads
    function automatic frame_phase_e phase_of(input int step, input int res_w);
        if (step == 0)
            return PH_SAMPLE;
        else if (step > res_w)
            return PH_LOAD;
        else
            return PH_DECIDE;
    endfunction

endpackage

// File: rtl/aux_tick_gen.sv
module aux_tick_gen #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             tick_o
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] lim;

    always_comb begin
        span   = (CNT_W + 1)'(1) << div_sel_i;
        lim    = CNT_W'(span - 1'b1);
        tick_o = run_i && (st_q.cnt == lim);
        st_d   = st_q;
        if (!run_i || tick_o)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R2: the divider count never passes the latched limit while running
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (st_q.cnt <= lim));

endmodule

// File: rtl/aux_sar_frame.sv
module aux_sar_frame
    import aux_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic             load_o
);
    localparam int LOAD_STEP = RES_W + 1;
    localparam int STEP_W    = $clog2(LOAD_STEP + 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [RES_W-1:0]  trial;
    } frame_state_t;

    frame_state_t st_d, st_q;
    frame_phase_e phase;

    always_comb begin
        phase   = phase_of(int'(st_q.step), RES_W);
        load_o  = tick_i && (phase == PH_LOAD);
        trial_o = st_q.trial;
        st_d    = st_q;
        if (!run_i) begin
            st_d = '0;
        end else if (tick_i) begin
            if (phase == PH_LOAD) begin
                st_d.step  = '0;
                st_d.trial = '0;
            end else begin
                st_d.step = st_q.step + 1'b1;
                for (int b = 0; b < RES_W; b++) begin
                    // decide bit b at step RES_W-b
                    if (int'(st_q.step) == RES_W - b && !cmp_i)
                        st_d.trial[b] = 1'b0;
                    // try bit b at step RES_W-1-b (MSB at the sample step)
                    if (int'(st_q.step) == RES_W - 1 - b)
                        st_d.trial[b] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R4: the step counter never runs past the load step
    p_step_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.step) <= LOAD_STEP);

    // R4: nothing is driven to the DAC during the sample phase
    p_sample_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step == '0) |-> (st_q.trial == '0));

endmodule

// File: rtl/aux_avg_unit.sv
module aux_avg_unit #(
    parameter int RES_W     = 10,
    parameter int MAX_SHIFT = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             run_i,
    input  logic                             load_i,
    input  logic [RES_W-1:0]                 code_i,
    input  logic [$clog2(MAX_SHIFT+1)-1:0]   shift_i,
    output logic                             final_o,
    output logic [RES_W-1:0]                 avg_o
);
    localparam int ACC_W    = RES_W + MAX_SHIFT;
    localparam int MAX_CODE = (1 << RES_W) - 1;

    typedef struct packed {
        logic [ACC_W-1:0]     sum;
        logic [MAX_SHIFT-1:0] cnt;
    } acc_state_t;

    acc_state_t           st_d, st_q;
    logic [MAX_SHIFT:0]   n_conv;
    logic [MAX_SHIFT-1:0] last_idx;
    logic [ACC_W-1:0]     sum_next;

    always_comb begin
        n_conv   = (MAX_SHIFT + 1)'(1) << shift_i;
        last_idx = MAX_SHIFT'(n_conv - 1'b1);
        sum_next = st_q.sum + ACC_W'(code_i);
        final_o  = load_i && (st_q.cnt == last_idx);
        avg_o    = RES_W'(sum_next >> shift_i);
        st_d     = st_q;
        if (!run_i || final_o) begin
            st_d = '0;
        end else if (load_i) begin
            st_d.sum = sum_next;
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R6: the running sum is bounded by full scale times conversions summed
    p_acc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sum <= ACC_W'(st_q.cnt) * ACC_W'(MAX_CODE));

endmodule

// File: rtl/aux_conv_seq.sv
module aux_conv_seq #(
    parameter int RES_W     = 10,
    parameter int SEL_W     = 3,
    parameter int MAX_SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SEL_W-1:0] div_sel_i,
    input  logic [SEL_W-1:0] avg_sel_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    localparam int SH_W = $clog2(MAX_SHIFT + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [SEL_W-1:0] div;
        logic [SH_W-1:0]  shift;
        logic [RES_W-1:0] result;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic             tick, load, fin;
    logic [RES_W-1:0] avg;

    function automatic logic [SH_W-1:0] sel_to_shift(input logic [SEL_W-1:0] sel);
        if (int'(sel) > MAX_SHIFT)
            return SH_W'(MAX_SHIFT);
        else
            return SH_W'(sel);
    endfunction

    aux_tick_gen #(.SEL_W(SEL_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (st_q.busy),
        .div_sel_i (st_q.div),
        .tick_o    (tick)
    );

    aux_sar_frame #(.RES_W(RES_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (st_q.busy),
        .tick_i  (tick),
        .cmp_i   (cmp_i),
        .trial_o (dac_code_o),
        .load_o  (load)
    );

    aux_avg_unit #(.RES_W(RES_W), .MAX_SHIFT(MAX_SHIFT)) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (st_q.busy),
        .load_i  (load),
        .code_i  (dac_code_o),
        .shift_i (st_q.shift),
        .final_o (fin),
        .avg_o   (avg)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.div   = div_sel_i;
                st_d.shift = sel_to_shift(avg_sel_i);
            end
        end else if (fin) begin
            st_d.busy   = 1'b0;
            st_d.done   = 1'b1;
            st_d.result = avg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign result_o = st_q.result;

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: busy only drops together with done
    p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7: latched settings stay fixed through a measurement
    p_settings_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || ($stable(st_q.div) && $stable(st_q.shift))));

    // R9: the result register only moves with done
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

endmodule

// File: tb/aux_conv_seq_test.sv
module aux_conv_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] div_sel = '0;
    logic [2:0] avg_sel = '0;
    logic [9:0] vin = '0;
    logic       cmp;
    logic [9:0] dac;
    logic       busy, done;
    logic [9:0] result;

    int errors = 0;
    int checks = 0;

    // reference model state
    bit m_busy = 0, m_done = 0;
    int m_c = 0, m_n = 1, m_a = 1, m_total = 0, m_sum = 0, m_res = 0;
    int vbase = 0, vstep = 0;

    always #10 clk = ~clk;

    // ideal comparator: 1 when trial code is at or below the level
    assign cmp = (dac <= vin);

    aux_conv_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .div_sel_i  (div_sel),
        .avg_sel_i  (avg_sel),
        .cmp_i      (cmp),
        .dac_code_o (dac),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result)
    );

    function automatic int vin_of(input int k);
        return (vbase + k * vstep) % 1024;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model, advanced on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_c = 0; m_res = 0;
        end else if (m_busy) begin
            m_done = 0;
            if (m_c == m_total - 1) begin
                m_busy = 0;
                m_done = 1;
                m_res  = m_sum / m_a;
            end else begin
                m_c++;
            end
        end else begin
            m_done = 0;
            if (start) begin
                m_busy  = 1;
                m_c     = 0;
                m_n     = 1 << div_sel;
                m_a     = 1 << ((avg_sel > 5) ? 5 : avg_sel);
                m_total = 12 * m_n * m_a;
                m_sum   = 0;
                for (int k = 0; k < m_a; k++) m_sum += vin_of(k);
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_busy) vin = 10'(vin_of(m_c / (12 * m_n)));
            chk(busy == m_busy, "R2 busy", busy, m_busy);
            chk(done == m_done, "R8 done", done, m_done);
            chk(result == 10'(m_res), m_done ? "R6 result" : "R9 result hold",
                result, m_res);
            if (!m_busy)
                chk(dac == 0, "R4 idle dac", dac, 0);
            else if (m_c < m_n)
                chk(dac == 0, "R4 pre-sample dac", dac, 0);
            else if (m_c == m_n)
                chk(dac == 10'd512, "R4 MSB trial", dac, 512);
            else if (m_c == 2 * m_n)
                chk(dac == ((vin_of(0) >= 512) ? 10'd768 : 10'd256),
                    "R5 second trial", dac, (vin_of(0) >= 512) ? 768 : 256);
        end
    end

    task automatic run_case(input int dsel, input int asel, input int base,
                            input int stp, input bit disturb);
        int len = 0;
        int exp_len;
        @(negedge clk);
        vbase = base; vstep = stp;
        div_sel = 3'(dsel); avg_sel = 3'(asel); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            len++;
            @(negedge clk);
            if (disturb) begin
                start   = ~start;
                div_sel = div_sel + 3'd1;
                avg_sel = avg_sel + 3'd3;
            end
        end
        start = 1'b0;
        exp_len = 12 * (1 << dsel) * (1 << ((asel > 5) ? 5 : asel));
        chk(len == exp_len, (asel > 5) ? "R3 length" : (disturb ? "R7 length" : "R2 length"),
            len, exp_len);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
        chk(result == 0, "R1 reset result", result, 0);
        chk(dac == 0, "R1 reset dac", dac, 0);

        run_case(0, 0, 0, 0, 0);        // R5 zero level
        run_case(0, 0, 1023, 0, 0);     // R5 full scale
        run_case(1, 0, 341, 0, 0);      // R5 alternating bits
        run_case(1, 1, 300, 7, 0);      // R6 two conversions, odd sum
        run_case(3, 2, 517, 101, 0);    // R6 four varying conversions
        run_case(2, 3, 1000, 13, 0);    // R6 wraps through full scale
        run_case(0, 4, 5, 3, 0);        // R3 sixteen
        run_case(0, 5, 900, 9, 0);      // R3 thirty-two
        run_case(0, 6, 10, 11, 0);      // R3 code 6 gives 32
        run_case(1, 7, 777, 1, 0);      // R3 code 7 gives 32
        run_case(4, 0, 600, 0, 0);      // R2 divide by 16
        run_case(5, 0, 128, 0, 0);      // R2 divide by 32
        run_case(6, 0, 64, 0, 0);       // R2 divide by 64
        run_case(7, 0, 513, 0, 0);      // R2 divide by 128
        run_case(2, 2, 222, 55, 1);     // R7 start and settings toggled while busy
        run_case(0, 1, 1, 1, 1);        // R7 again with fast clock

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule